// File: doc/BRIEF.md
# Fully Associative Tag Directory

This block is the lookup half of a cache in which any memory block may occupy any entry. It keeps, for each entry, the block number of the resident block together with a flag saying whether the entry holds anything. A lookup address is split into a block number and a word offset. The block number is compared against every entry at the same time, which yields a hit flag and the number of the matching entry. The offset is passed straight through so that a data array can select the word inside the block.

When a lookup misses, the directory proposes an entry to replace. Empty entries are used first, lowest number first. Once every entry is occupied, the proposal comes from a free-running pseudo-random generator. An install strobe writes the missing block number into the proposed entry. A flush input empties the whole directory in one cycle. The data array itself and all traffic to main memory belong to the surrounding cache.

Top module: `assoc_tag_dir`

## Requirements
- R1: The block number is `lkp_addr[19:3]` and the word offset is `lkp_addr[2:0]`. The offset is forwarded unchanged on `word_sel` and never affects a hit.
- R2: `lkp_hit` is 1 only when an occupied entry holds the block number of `lkp_addr`. In that case `lkp_idx` names that entry. On a miss, `lkp_idx` is 0.
- R3: After a synchronous active-low reset, every entry is empty, every lookup misses and `victim_idx` is 0.
- R4: When `ins_en` is 1 and the lookup misses, the block number is written into entry `victim_idx` and that entry becomes occupied. A lookup of the same block number in the next cycle hits at that entry.
- R5: An `ins_en` pulse while the lookup hits has no effect on the directory.
- R6: `flush` empties every entry in one cycle. It takes priority over a simultaneous `ins_en`.
- R7: The random source is a 16-bit register. Reset loads 0xACE1 into it. On every other clock edge it shifts left by one, and the new bit 0 is bit15 XOR bit13 XOR bit12 XOR bit10. It is never zero.
- R8: While any entry is empty, `victim_idx` is the lowest-numbered empty entry.
- R9: While all entries are occupied, `victim_idx` equals the random register modulo 8, which is its low three bits.
- R10: Any block number can be held in any entry. Eight block numbers that differ only in their upper bits fill all eight entries, and each one hits at the entry it was installed in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lkp_addr | input | 20 | Address under lookup and, on install, the block to install |
| ins_en | input | 1 | Install the looked-up block into the proposed entry on a miss |
| flush | input | 1 | Empty every entry |
| lkp_hit | output | 1 | Lookup hit |
| lkp_idx | output | 3 | Matching entry number |
| word_sel | output | 3 | Word offset within the block |
| victim_idx | output | 3 | Entry proposed for the next install |

## Verification
`lkp_hit`, `lkp_idx`, `word_sel` and `victim_idx` are combinational results of the current address and stored state, so they are due in the same cycle. The bench changes inputs on the falling edge and samples one nanosecond later, well before the next rising edge. An install or a flush lands on the next rising edge, so its effect is checked in the cycle after the strobe. The random register advances on every rising edge. The bench keeps its own copy of that register, updated on the same edges, and compares `victim_idx` against it only when all entries are occupied.

// File: rtl/atd_pkg.sv
// Package: shared constants and the random-source step function for the
// associative tag directory. Assumes a 16-bit maximal-length polynomial.
package atd_pkg;
    localparam int          RND_W    = 16;
    localparam logic [15:0] RND_SEED = 16'hACE1;

    // One left shift of the random register with XOR feedback into bit 0.
    function automatic logic [RND_W-1:0] rnd_step(input logic [RND_W-1:0] s);
        return {s[RND_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction
endpackage

// File: rtl/atd_rnd.sv
// Random source: free-running 16-bit shift register with XOR feedback.
// Assumes the seed is nonzero, so the register never locks up at zero.
module atd_rnd
    import atd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    output logic [RND_W-1:0] rnd
);
    // Load the seed under reset, otherwise advance every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rnd <= RND_SEED;
        else        rnd <= rnd_step(rnd);
    end

    AST_RND_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rnd != '0); // R7
endmodule

// File: rtl/atd_match.sv
// Parallel comparator: compares one block number against every entry and
// encodes the single matching entry. Assumes no two occupied entries hold
// the same block number, which the install rule guarantees.
module atd_match #(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 17,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [TAG_W-1:0]               tag,
    input  logic [ENTRIES-1:0][TAG_W-1:0]  tags,
    input  logic [ENTRIES-1:0]             valid,
    output logic                           hit,
    output logic [IDX_W-1:0]               idx
);
    logic [ENTRIES-1:0] match_vec;

    // One comparator per entry, qualified by that entry's occupied flag.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign match_vec[e] = valid[e] && (tags[e] == tag);
    end

    // OR-encode the match vector into an entry number (zero on a miss).
    always_comb begin
        idx = '0;
        for (int e = 0; e < ENTRIES; e++)
            if (match_vec[e]) idx = idx | IDX_W'(e);
    end

    assign hit = |match_vec;

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec)); // R2
endmodule

// File: rtl/atd_victim.sv
// Replacement chooser: proposes the lowest empty entry, or, when every
// entry is occupied, the random value reduced modulo the entry count.
module atd_victim
    import atd_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid,
    input  logic [RND_W-1:0]   rnd,
    output logic [IDX_W-1:0]   victim
);
    // Scan down so the lowest empty entry is the one left standing.
    always_comb begin
        victim = IDX_W'(rnd % RND_W'(ENTRIES));
        for (int e = ENTRIES - 1; e >= 0; e--)
            if (!valid[e]) victim = IDX_W'(e);
    end

    AST_VICTIM_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (valid != '1) |-> !valid[victim]); // R8
endmodule

// File: rtl/assoc_tag_dir.sv
// Fully associative tag directory: stores one block number and one
// occupied flag per entry, looks up all entries in parallel, and installs
// on a miss into the chooser's entry. Assumes the caller only strobes
// install after seeing a miss; an install on a hit is dropped.
module assoc_tag_dir
    import atd_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int OFF_W   = 3,
    parameter int ENTRIES = 8,
    localparam int TAG_W  = ADDR_W - OFF_W,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lkp_addr,
    input  logic              ins_en,
    input  logic              flush,
    output logic              lkp_hit,
    output logic [IDX_W-1:0]  lkp_idx,
    output logic [OFF_W-1:0]  word_sel,
    output logic [IDX_W-1:0]  victim_idx
);
    logic [ENTRIES-1:0][TAG_W-1:0] tags;
    logic [ENTRIES-1:0]            valid;
    logic [RND_W-1:0]              rnd;
    logic [TAG_W-1:0]              lkp_tag;

    assign lkp_tag  = lkp_addr[ADDR_W-1:OFF_W];
    assign word_sel = lkp_addr[OFF_W-1:0];

    atd_rnd i_rnd (.clk(clk), .rst_n(rst_n), .rnd(rnd));

    atd_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) i_match (
        .clk(clk), .rst_n(rst_n), .tag(lkp_tag), .tags(tags),
        .valid(valid), .hit(lkp_hit), .idx(lkp_idx));

    atd_victim #(.ENTRIES(ENTRIES)) i_victim (
        .clk(clk), .rst_n(rst_n), .valid(valid), .rnd(rnd),
        .victim(victim_idx));

    // Occupied flags: cleared by reset or flush, set by an install on a miss.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)           valid <= '0;
        else if (ins_en && !lkp_hit)   valid[victim_idx] <= 1'b1;
    end

    // Block-number store: written only by an install on a miss.
    always_ff @(posedge clk) begin
        if (rst_n && !flush && ins_en && !lkp_hit)
            tags[victim_idx] <= lkp_tag;
    end

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid == '0)); // R6
    AST_INSTALL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_en && !flush && !lkp_hit) |=>
            (valid[$past(victim_idx)] && tags[$past(victim_idx)] == $past(lkp_tag))); // R4
    AST_HIT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_en && !flush && lkp_hit) |=> $stable(valid) && $stable(tags)); // R5
endmodule

// File: tb/test_assoc_tag_dir.sv
module test_assoc_tag_dir;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] lkp_addr = '0;
    logic        ins_en = 1'b0;
    logic        flush = 1'b0;
    logic        lkp_hit;
    logic [2:0]  lkp_idx, word_sel, victim_idx;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] m_rnd;
    logic [16:0] sh_tag [8];

    always #5 clk = ~clk;

    assoc_tag_dir i_assoc_tag_dir (.clk(clk), .rst_n(rst_n), .lkp_addr(lkp_addr),
        .ins_en(ins_en), .flush(flush), .lkp_hit(lkp_hit), .lkp_idx(lkp_idx),
        .word_sel(word_sel), .victim_idx(victim_idx));

    // Reference random register built from R7.
    always @(posedge clk) begin
        if (!rst_n) m_rnd <= 16'hACE1;
        else        m_rnd <= {m_rnd[14:0], m_rnd[15] ^ m_rnd[13] ^ m_rnd[12] ^ m_rnd[10]};
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic nxt();
        @(posedge clk); @(negedge clk);
    endtask

    // Drive an address for lookup and sample its combinational results.
    task automatic look(input logic [16:0] tag, input logic [2:0] off);
        lkp_addr = {tag, off}; ins_en = 1'b0; #1;
    endtask

    // Install a block on a miss, returning the proposed entry.
    task automatic install(input logic [16:0] tag, output logic [2:0] v);
        lkp_addr = {tag, 3'd0}; ins_en = 1'b1; #1;
        v = victim_idx;
        nxt(); ins_en = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; nxt(); nxt(); rst_n = 1'b1;
        look(17'h00000, 3'd0);
        chk("R3 hit after reset", 32'(lkp_hit), 0);
        chk("R3 victim after reset", 32'(victim_idx), 0);
        chk("R2 idx on miss", 32'(lkp_idx), 0);
    endtask

    task automatic t_fill();
        logic [2:0] v;
        for (int i = 0; i < 8; i++) begin
            sh_tag[i] = {14'(i * 3 + 5), 3'b101};
            look(sh_tag[i], 3'd0);
            chk("R8 lowest empty", 32'(victim_idx), 32'(i));
            install(sh_tag[i], v);
            look(sh_tag[i], 3'd0);
            chk("R4 hit after install", 32'(lkp_hit), 1);
            chk("R4 idx after install", 32'(lkp_idx), 32'(i));
        end
    endtask

    task automatic t_hits();
        for (int i = 7; i >= 0; i--) begin
            look(sh_tag[i], 3'(i));
            chk("R10 hit", 32'(lkp_hit), 1);
            chk("R10 idx", 32'(lkp_idx), 32'(i));
            chk("R1 word_sel", 32'(word_sel), 32'(i));
        end
        look(17'h1FFFF, 3'd5);
        chk("R2 miss unknown", 32'(lkp_hit), 0);
        chk("R1 offset passes on miss", 32'(word_sel), 5);
    endtask

    task automatic t_install_on_hit();
        logic [2:0] v;
        install(sh_tag[2], v);
        for (int i = 0; i < 8; i++) begin
            look(sh_tag[i], 3'd0);
            chk("R5 entry kept", 32'(lkp_idx), 32'(i));
        end
    endtask

    task automatic t_random();
        logic [2:0] v;
        logic [16:0] t;
        for (int k = 0; k < 6; k++) begin
            t = 17'h0AB00 + 17'(k);
            look(t, 3'd0);
            chk("R9 victim from random", 32'(victim_idx), 32'(m_rnd[2:0]));
            install(t, v);
            sh_tag[v] = t;
            look(t, 3'd0);
            chk("R4 random install hit", 32'(lkp_hit), 1);
            chk("R4 random install idx", 32'(lkp_idx), 32'(v));
        end
    endtask

    task automatic t_flush();
        flush = 1'b1; lkp_addr = 20'h12345; ins_en = 1'b1; nxt();
        flush = 1'b0; ins_en = 1'b0;
        look(17'(20'h12345 >> 3), 3'd5);
        chk("R6 flush beats install", 32'(lkp_hit), 0);
        for (int i = 0; i < 8; i++) begin
            look(sh_tag[i], 3'd0);
            chk("R6 flushed miss", 32'(lkp_hit), 0);
        end
        chk("R6 victim after flush", 32'(victim_idx), 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_fill();
        t_hits();
        t_install_on_hit();
        t_random();
        t_flush();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule